// File: doc/BRIEF.md
# PHY Management Command Engine

This block issues PHY management read and write transactions on a two-wire serial link made of a management clock (MDC) and a shared data line (MDIO). The host reaches it through a small byte-wide register file. That file holds the target PHY address and a clock-speed select, the PHY register number, a 16-bit data word, and a control byte with two command bits. A command bit set by the host starts exactly one management frame. The hardware clears the bit when the frame ends, so software finds out that a transaction is complete by reading the control byte until the bit is zero.

For a write, the host loads the data word first and then sets the write command bit. For a read, the engine releases MDIO from the turnaround onward and shifts in the sixteen bits the PHY returns. When the frame ends, it stores them in the data word. MDC runs only while a frame is in progress. Its period is chosen per transaction from two parameterised divisors of the system clock.

Top module: `mgmt_cmd_engine`

## Requirements
- R1: Offset 0 holds the PHY address in bits 4:0 and the fast-clock select in bit 5. It reads back bits 5:0, and bits 7:6 read as zero.
- R2: Offset 2 holds the PHY register number in bits 4:0. Bits 7:5 read as zero.
- R3: The 16-bit data word is reached at offset 3 (bits 7:0) and offset 4 (bits 15:8). The host can write and read it back. When a read frame ends, the word holds the 16 bits sampled from MDIO, first sample in bit 15.
- R4: Offset 1 is the control byte. Bit 6 is the read command and bit 5 is the write command, and setting either one starts a frame. If both are written as one at once, only the read bit is kept and a read frame runs.
- R5: A command bit reads as one from the cycle after it is written until the frame ends, and then clears by itself. One frame lasts 64 MDC periods.
- R6: A frame is sent most significant bit first in this order: 32 ones, start 01, opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, a turnaround, and 16 data bits. On a write the turnaround is driven as 10 and the data bits come from the data word.
- R7: The MDC period is SLOW_DIV system clocks, or FAST_DIV when the fast select was set at the start of the frame. MDC is high for half of each period and stays low while no frame runs.
- R8: MDIO output changes only on MDC falling edges, and input is sampled on MDC rising edges. On a read, the output enable is low for the turnaround and all 16 data bits.
- R9: A control-byte write made while a command bit is set has no effect. Writing zero to the control byte while idle starts nothing and leaves both command bits clear.
- R10: After reset all registers read zero, MDC is low and the MDIO output enable is low.
- R11: Offsets 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register byte offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data, combinational on host_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO input value |

## Verification
The bench builds the engine with SLOW_DIV of 8 and FAST_DIV of 4. At these values a whole frame takes a few hundred cycles, so the bench can sweep all 32 PHY addresses, each paired with a distinct register number, and alternate reads, writes and both clock rates. A behavioural PHY in the bench decodes every frame bit by bit at MDC rising edges and returns computed read data. The bench also counts MDC high cycles and frame lengths against the arithmetic values. The small divisors also leave room for the command-while-busy and zero-write cases, which are observed over windows longer than a whole frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [2:0] OFF_PHY   = 3'd0;
  localparam logic [2:0] OFF_CTRL  = 3'd1;
  localparam logic [2:0] OFF_REG   = 3'd2;
  localparam logic [2:0] OFF_DLO   = 3'd3;
  localparam logic [2:0] OFF_DHI   = 3'd4;
  localparam int unsigned CTRL_RD_BIT = 6;
  localparam int unsigned CTRL_WR_BIT = 5;
  localparam int unsigned FAST_BIT    = 5;
  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned DATA_W      = 16;
endpackage

// File: rtl/mgmt_clkgen.sv
module mgmt_clkgen #(
  parameter int unsigned SLOW_DIV = 64,
  parameter int unsigned FAST_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int unsigned CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          mdc_q, mdc_n;
  logic [CW-1:0] last_cnt, half_cnt;

  assign last_cnt = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign half_cnt = fast ? CW'(FAST_DIV / 2 - 1) : CW'(SLOW_DIV / 2 - 1);
  assign rise = run && (cnt_q == half_cnt);
  assign fall = run && (cnt_q == last_cnt);

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else begin
      if (fall) cnt_n = '0;
      else      cnt_n = cnt_q + 1'b1;
      if (rise)      mdc_n = 1'b1;
      else if (fall) mdc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc = mdc_q;

  assert_rise_from_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !mdc_q);
  assert_fall_from_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> mdc_q);
endmodule

// File: rtl/mgmt_shifter.sv
module mgmt_shifter #(
  parameter int unsigned PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_rd,
  input  logic        cmd_wr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        fast_sel,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_in,
  output logic        busy,
  output logic        fast_q,
  output logic        done,
  output logic        done_rd,
  output logic [15:0] rd_capture,
  output logic        mdio_out,
  output logic        mdio_oe
);
  localparam int unsigned FRAME_BITS = PRE_BITS + 32;
  localparam int unsigned IW         = $clog2(FRAME_BITS);
  localparam int unsigned TA_IDX     = PRE_BITS + 14;
  localparam int unsigned DATA_IDX   = PRE_BITS + 16;

  logic                  busy_q, busy_n;
  logic                  op_rd_q, op_rd_n;
  logic                  fast_n;
  logic [IW-1:0]         idx_q, idx_n;
  logic [FRAME_BITS-1:0] frame_q, frame_n;
  logic [15:0]           cap_q, cap_n;
  logic                  last_bit;

  assign last_bit = (idx_q == IW'(FRAME_BITS - 1));
  assign done     = busy_q && fall && last_bit;
  assign done_rd  = done && op_rd_q;

  always_comb begin
    busy_n  = busy_q;
    op_rd_n = op_rd_q;
    fast_n  = fast_q;
    idx_n   = idx_q;
    frame_n = frame_q;
    cap_n   = cap_q;
    if (!busy_q) begin
      if (cmd_rd || cmd_wr) begin
        busy_n  = 1'b1;
        op_rd_n = cmd_rd;
        fast_n  = fast_sel;
        idx_n   = '0;
        frame_n = {{PRE_BITS{1'b1}}, 2'b01,
                   cmd_rd ? 2'b10 : 2'b01,
                   phy_addr, reg_addr,
                   cmd_rd ? 2'b11 : 2'b10,
                   cmd_rd ? 16'h0000 : wr_data};
      end
    end else begin
      if (rise && op_rd_q && (idx_q >= IW'(DATA_IDX)))
        cap_n = {cap_q[14:0], mdio_in};
      if (fall) begin
        if (last_bit) begin
          busy_n = 1'b0;
        end else begin
          idx_n   = idx_q + 1'b1;
          frame_n = {frame_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_rd_q <= 1'b0;
      fast_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
      cap_q   <= '0;
    end else begin
      busy_q  <= busy_n;
      op_rd_q <= op_rd_n;
      fast_q  <= fast_n;
      idx_q   <= idx_n;
      frame_q <= frame_n;
      cap_q   <= cap_n;
    end
  end

  assign busy       = busy_q;
  assign rd_capture = cap_q;
  assign mdio_oe    = busy_q && !(op_rd_q && (idx_q >= IW'(TA_IDX)));
  assign mdio_out   = mdio_oe && frame_q[FRAME_BITS-1];

  assert_frame_opens_with_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (mdio_out && idx_q == '0));
  assert_done_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  assert_bit_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall) |=> $stable(idx_q));
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        done,
  input  logic        done_rd,
  input  logic [15:0] rd_capture,
  output logic [4:0]  phy_addr,
  output logic        fast_sel,
  output logic [4:0]  reg_addr,
  output logic [15:0] wr_data,
  output logic        cmd_rd,
  output logic        cmd_wr
);
  logic [5:0]  phy_q, phy_n;
  logic [4:0]  reg_q, reg_n;
  logic [15:0] data_q, data_n;
  logic        rd_q, rd_n, wr_q, wr_n;
  logic        ctrl_wr;

  assign ctrl_wr = host_we && (host_addr == OFF_CTRL);

  always_comb begin
    phy_n  = phy_q;
    reg_n  = reg_q;
    data_n = data_q;
    rd_n   = rd_q;
    wr_n   = wr_q;
    if (host_we && host_addr == OFF_PHY) phy_n = host_wdata[5:0];
    if (host_we && host_addr == OFF_REG) reg_n = host_wdata[4:0];
    if (host_we && host_addr == OFF_DLO) data_n[7:0]  = host_wdata;
    if (host_we && host_addr == OFF_DHI) data_n[15:8] = host_wdata;
    if (done_rd) data_n = rd_capture;
    if (done) begin
      rd_n = 1'b0;
      wr_n = 1'b0;
    end else if (ctrl_wr && !rd_q && !wr_q) begin
      rd_n = host_wdata[CTRL_RD_BIT];
      wr_n = host_wdata[CTRL_WR_BIT] && !host_wdata[CTRL_RD_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      phy_q  <= phy_n;
      reg_q  <= reg_n;
      data_q <= data_n;
      rd_q   <= rd_n;
      wr_q   <= wr_n;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    case (host_addr)
      OFF_PHY:  host_rdata = {2'b00, phy_q};
      OFF_CTRL: host_rdata = {1'b0, rd_q, wr_q, 5'b00000};
      OFF_REG:  host_rdata = {3'b000, reg_q};
      OFF_DLO:  host_rdata = data_q[7:0];
      OFF_DHI:  host_rdata = data_q[15:8];
      default:  host_rdata = 8'h00;
    endcase
  end

  assign phy_addr = phy_q[4:0];
  assign fast_sel = phy_q[FAST_BIT];
  assign reg_addr = reg_q;
  assign wr_data  = data_q;
  assign cmd_rd   = rd_q;
  assign cmd_wr   = wr_q;

  assert_one_command_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_q, wr_q}));
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (rd_q || wr_q) && !done) |=> ({rd_q, wr_q} == $past({rd_q, wr_q})));
endmodule

// File: rtl/mgmt_cmd_engine.sv
module mgmt_cmd_engine #(
  parameter int unsigned SLOW_DIV = 64,
  parameter int unsigned FAST_DIV = 16,
  parameter int unsigned PRE_BITS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       mdc,
  output logic       mdio_out,
  output logic       mdio_oe,
  input  logic       mdio_in
);
  logic [4:0]  phy_addr, reg_addr;
  logic [15:0] wr_data, rd_capture;
  logic        fast_sel, fast_q, cmd_rd, cmd_wr;
  logic        busy, done, done_rd, rise, fall;

  mgmt_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .done(done), .done_rd(done_rd), .rd_capture(rd_capture),
    .phy_addr(phy_addr), .fast_sel(fast_sel), .reg_addr(reg_addr),
    .wr_data(wr_data), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr)
  );

  mgmt_clkgen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .fast(fast_q),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mgmt_shifter #(.PRE_BITS(PRE_BITS)) u_shifter (
    .clk(clk), .rst_n(rst_n),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .fast_sel(fast_sel), .rise(rise), .fall(fall), .mdio_in(mdio_in),
    .busy(busy), .fast_q(fast_q), .done(done), .done_rd(done_rd),
    .rd_capture(rd_capture), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  assert_idle_lines_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  assert_busy_has_command_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cmd_rd || cmd_wr));
endmodule

// File: tb/mgmt_cmd_engine_tb.sv
module mgmt_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW = 8;
  localparam int FAST = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       mdc, mdio_out, mdio_oe;
  logic       mdio_in = 1'b0;

  int checks = 0;
  int errors = 0;
  int rise_total = 0;
  int hi_cnt = 0;
  logic [15:0] phy_val = 16'h0000;
  logic obit [64];
  logic oen  [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_cmd_engine #(.SLOW_DIV(SLOW), .FAST_DIV(FAST), .PRE_BITS(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // behavioural PHY: record each bit at MDC rise, answer after MDC fall
  always @(posedge mdc) begin
    obit[rise_total % 64] = mdio_out;
    oen[rise_total % 64]  = mdio_oe;
    rise_total = rise_total + 1;
  end
  always @(negedge mdc) begin
    if ((rise_total % 64) >= 48) mdio_in = phy_val[63 - (rise_total % 64)];
    else mdio_in = 1'b0;
  end
  always @(posedge clk) if (mdc) hi_cnt <= hi_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic logic [4:0] field5(input int start);
    logic [4:0] v;
    for (int i = 0; i < 5; i++) v[4-i] = obit[start+i];
    return v;
  endfunction

  task automatic txn(input bit is_rd, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input bit fast);
    logic [7:0] v, lo, hi;
    int cyc, hbase, div;
    logic [15:0] got;
    bit pre_ok, oe_ok;
    div = fast ? FAST : SLOW;
    phy_val = {pa, ra, 6'h15} ^ 16'hA5C3;
    wr(3'd0, {2'b00, fast, pa});
    wr(3'd2, {3'b000, ra});
    wr(3'd3, wd[7:0]);
    wr(3'd4, wd[15:8]);
    hbase = hi_cnt;
    wr(3'd1, is_rd ? 8'h40 : 8'h20);
    cyc = 1;
    rd(3'd1, v);
    chk(v == (is_rd ? 8'h40 : 8'h20), "R5 command bit held during frame", v, is_rd ? 8'h40 : 8'h20);
    while (v != 8'h00 && cyc < 5000) begin
      rd(3'd1, v);
      cyc++;
    end
    chk(cyc >= 64*div && cyc <= 64*div + 3, "R5 frame length", cyc, 64*div);
    chk(hi_cnt - hbase == 32*div, "R7 MDC high cycles", hi_cnt - hbase, 32*div);
    pre_ok = 1'b1;
    for (int i = 0; i < 32; i++) if (!(obit[i] && oen[i])) pre_ok = 1'b0;
    chk(pre_ok, "R6 preamble", pre_ok, 1);
    chk({obit[32], obit[33]} == 2'b01, "R6 start", {obit[32], obit[33]}, 1);
    chk({obit[34], obit[35]} == (is_rd ? 2'b10 : 2'b01), "R6 opcode",
        {obit[34], obit[35]}, is_rd ? 2 : 1);
    chk(field5(36) == pa, "R6 phy address", field5(36), pa);
    chk(field5(41) == ra, "R6 register number", field5(41), ra);
    if (is_rd) begin
      oe_ok = 1'b1;
      for (int i = 46; i < 64; i++) if (oen[i]) oe_ok = 1'b0;
      chk(oe_ok, "R8 read releases MDIO", oe_ok, 1);
      rd(3'd3, lo);
      rd(3'd4, hi);
      chk({hi, lo} == phy_val, "R3 read result", {hi, lo}, phy_val);
    end else begin
      chk({obit[46], obit[47]} == 2'b10 && oen[46] && oen[47], "R6 write turnaround",
          {obit[46], obit[47]}, 2);
      for (int i = 0; i < 16; i++) got[15-i] = obit[48+i];
      chk(got == wd, "R6 write data", got, wd);
    end
  endtask

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    #1;
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 lines at reset", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk(v == 8'h00, "R10 register reset value", v, 0);
    end
    wr(3'd0, 8'hFF); rd(3'd0, v); chk(v == 8'h3F, "R1 readback", v, 8'h3F);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk(v == 8'h1F, "R2 readback", v, 8'h1F);
    wr(3'd3, 8'h5A); rd(3'd3, v); chk(v == 8'h5A, "R3 low byte", v, 8'h5A);
    wr(3'd4, 8'hC3); rd(3'd4, v); chk(v == 8'hC3, "R3 high byte", v, 8'hC3);
    for (int a = 5; a < 8; a++) begin
      wr(a[2:0], 8'hFF); rd(a[2:0], v);
      chk(v == 8'h00, "R11 unused offset", v, 0);
    end
    // zero write while idle starts nothing
    base = rise_total;
    wr(3'd1, 8'h00);
    repeat (100) @(negedge clk);
    rd(3'd1, v);
    chk(v == 8'h00 && rise_total == base, "R9 zero write idle", rise_total - base, 0);
    // sweep all PHY addresses
    for (int p = 0; p < 32; p++)
      txn(p[0], p[4:0], 5'(31 - p), 16'(p * 16'h0901 ^ 16'h3C5A), p[1]);
    // both bits written together
    base = rise_total;
    phy_val = 16'h0;
    wr(3'd1, 8'h60);
    rd(3'd1, v);
    chk(v == 8'h40, "R4 read wins over write", v, 8'h40);
    repeat (64*SLOW + 10) @(negedge clk);
    chk({obit[34], obit[35]} == 2'b10 && rise_total - base == 64, "R4 read frame sent",
        {obit[34], obit[35]}, 2);
    // commands while busy are ignored
    base = rise_total;
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h20);
    repeat (20) @(negedge clk);
    wr(3'd1, 8'h40);
    wr(3'd1, 8'h00);
    rd(3'd1, v);
    chk(v == 8'h20, "R9 busy write keeps command", v, 8'h20);
    repeat (2*64*SLOW + 20) @(negedge clk);
    rd(3'd1, v);
    chk(v == 8'h00 && rise_total - base == 64, "R9 no second frame", rise_total - base, 64);
    chk({obit[34], obit[35]} == 2'b01, "R9 original write frame kept", {obit[34], obit[35]}, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule